// File: doc/BRIEF.md
# Shifted 64-bit Pointer Adder with Split Halves

This block forms a 64-bit address from a 64-bit base and an offset that is shifted left by a small immediate (0 to 7) before it is added. The offset is either a full 64-bit value or a 32-bit value. A 32-bit offset is zero-extended or sign-extended to 64 bits before the shift. A typical use is scaling an array index by the element size and adding it to a pointer.

The addition is split into two 32-bit halves. The low stage extends and shifts the offset, then adds the two low words. It sends a private side channel to the high stage. That channel carries the low-half carry and the upper 32 bits of the extended, shifted offset, which include any offset bits pushed past bit 31. A pipeline register sits between the halves. The high stage then adds the registered base upper word, the spilled offset word and the carry. Both halves of one operation are captured by the same register write, so the two stages always act as one 64-bit add. A result appears one clock after its operands are accepted.

Top module: `ptr_shift_adder`

## Requirements
- R1: After a synchronous active-low reset, `out_valid` is 0 and `out_sum` is 0.
- R2: With `in_mode` = 2'b00 (full offset), `out_sum` = `in_base` + (`in_offset` << `in_shift`) modulo 2^64, for every shift from 0 to 7.
- R3: With `in_mode` = 2'b01, only `in_offset[31:0]` is used, zero-extended to 64 bits before the shift. `in_offset[63:32]` has no effect on `out_sum`.
- R4: With `in_mode` = 2'b10, only `in_offset[31:0]` is used, sign-extended from bit 31 to 64 bits before the shift. `in_offset[63:32]` has no effect on `out_sum`.
- R5: `in_mode` = 2'b11 gives the same result as the full-offset mode 2'b00.
- R6: A carry out of bit 31 of the low-half sum is added into the upper 32 bits of the result.
- R7: Offset bits that the shift moves past bit 31 appear in the upper half of the sum with their full weight.
- R8: `out_valid` is high in the cycle after a clock edge that samples `in_valid` high. The `out_sum` shown then belongs to the operands of that edge, including when operations arrive on back-to-back cycles.
- R9: After a clock edge that samples `in_valid` low, `out_valid` is 0 and `out_sum` keeps its previous value.
- R10: A sum that exceeds 2^64 - 1 wraps, and only its low 64 bits are kept.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; all state updates on the rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| in_valid | input | 1 | Operands on this cycle are to be added |
| in_mode | input | 2 | Offset kind: 00 full, 01 zero-extended 32-bit, 10 sign-extended 32-bit, 11 as 00 |
| in_shift | input | 3 | Left shift applied to the extended offset, 0 to 7 |
| in_base | input | 64 | Base pointer |
| in_offset | input | 64 | Offset; only bits 31:0 are used in the 32-bit modes |
| out_valid | output | 1 | `out_sum` holds a fresh result |
| out_sum | output | 64 | Base plus shifted offset |

## Verification
The assertions assume that `in_mode`, `in_shift`, `in_base` and `in_offset` are known whenever `in_valid` is high. They also assume that every operation is sampled by one rising edge, with no stall or back-pressure: each accepted operation owns exactly one output cycle. The bench changes inputs only on falling clock edges, sets every operand field before it raises `in_valid`, and reads the outputs one falling edge later. It also puts non-zero data on `in_offset[63:32]` in the 32-bit modes, so that an ignored field that leaks into the sum shows up.

// File: rtl/ptradd_pkg.sv
// Package: ptradd_pkg
// Shared widths and types for the split shifted pointer adder.
// Assumes a 64-bit pointer split into two equal halves.
package ptradd_pkg;

    localparam int PTR_W   = 64;
    localparam int HALF_W  = PTR_W / 2;
    localparam int SHIFT_W = 3;

    // Offset interpretation selected per operation
    typedef enum logic [1:0] {
        OFS_FULL = 2'b00,
        OFS_ZEXT = 2'b01,
        OFS_SEXT = 2'b10,
        OFS_ALT  = 2'b11
    } ofs_mode_e;

    // Private low-to-high side channel
    typedef struct packed {
        logic              carry;
        logic [HALF_W-1:0] upper;
    } spill_t;

endpackage

// File: rtl/ptradd_barrel.sv
// Module: ptradd_barrel
// Logarithmic left shifter: one generated stage per shift-amount bit.
// Assumes the shift amount is unsigned; bits shifted past the top are lost.
module ptradd_barrel #(
    parameter int DATA_W  = 64,
    parameter int SHAMT_W = 3
) (
    input  logic [DATA_W-1:0]  din,
    input  logic [SHAMT_W-1:0] shamt,
    output logic [DATA_W-1:0]  dout
);

    logic [DATA_W-1:0] stg [0:SHAMT_W];

    // Feed the input into the first stage
    always_comb stg[0] = din;

    genvar gi;
    generate
        for (gi = 0; gi < SHAMT_W; gi++) begin : g_stage
            localparam int STEP = 1 << gi;
            // Conditionally shift by this stage's power of two
            always_comb stg[gi+1] = shamt[gi] ? (stg[gi] << STEP) : stg[gi];
        end
    endgenerate

    // Present the last stage
    always_comb dout = stg[SHAMT_W];

endmodule

// File: rtl/ptradd_lo_stage.sv
// Module: ptradd_lo_stage
// Low-half stage: extends the offset by mode, shifts it, adds the low
// words and produces the side channel (carry plus upper shifted word).
// Assumes it is purely combinational and is registered by the caller.
module ptradd_lo_stage
    import ptradd_pkg::*;
(
    input  logic [1:0]         mode,
    input  logic [SHIFT_W-1:0] shamt,
    input  logic [HALF_W-1:0]  base_lo,
    input  logic [PTR_W-1:0]   offset,
    output logic [HALF_W-1:0]  sum_lo,
    output spill_t             spill
);

    ofs_mode_e         mode_e;
    logic [PTR_W-1:0]  ofs_ext;
    logic [PTR_W-1:0]  ofs_shl;
    logic [HALF_W:0]   lo_wide;

    // Decode the mode field into the enum
    always_comb mode_e = ofs_mode_e'(mode);

    // Widen the offset according to the selected interpretation
    always_comb begin
        unique case (mode_e)
            OFS_ZEXT: ofs_ext = {{HALF_W{1'b0}}, offset[HALF_W-1:0]};
            OFS_SEXT: ofs_ext = {{HALF_W{offset[HALF_W-1]}}, offset[HALF_W-1:0]};
            default:  ofs_ext = offset;
        endcase
    end

    ptradd_barrel #(
        .DATA_W  (PTR_W),
        .SHAMT_W (SHIFT_W)
    ) u_shl (
        .din   (ofs_ext),
        .shamt (shamt),
        .dout  (ofs_shl)
    );

    // Low-word addition with carry out
    always_comb lo_wide = {1'b0, base_lo} + {1'b0, ofs_shl[HALF_W-1:0]};

    // Split result and side channel
    always_comb begin
        sum_lo      = lo_wide[HALF_W-1:0];
        spill.carry = lo_wide[HALF_W];
        spill.upper = ofs_shl[PTR_W-1:HALF_W];
    end

endmodule

// File: rtl/ptradd_pipe.sv
// Module: ptradd_pipe
// Register between halves: captures the low result, the side channel and
// the base upper word together, so a high stage always sees its own low.
// Assumes synchronous active-low reset; holds contents when no operation.
module ptradd_pipe
    import ptradd_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              vld_i,
    input  logic [HALF_W-1:0] sum_lo_i,
    input  spill_t            spill_i,
    input  logic [HALF_W-1:0] base_hi_i,
    output logic              vld_o,
    output logic [HALF_W-1:0] sum_lo_o,
    output spill_t            spill_o,
    output logic [HALF_W-1:0] base_hi_o
);

    // Track which cycles carry a fresh result
    always_ff @(posedge clk) begin
        if (!rst_n) vld_o <= 1'b0;
        else        vld_o <= vld_i;
    end

    // Capture both halves' operands in one write
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sum_lo_o  <= '0;
            spill_o   <= '0;
            base_hi_o <= '0;
        end else if (vld_i) begin
            sum_lo_o  <= sum_lo_i;
            spill_o   <= spill_i;
            base_hi_o <= base_hi_i;
        end
    end

    AST_VALID_FOLLOWS : assert property (@(posedge clk) disable iff (!rst_n)
        vld_i |=> vld_o);                                         // R8
    AST_IDLE_NO_VALID : assert property (@(posedge clk) disable iff (!rst_n)
        !vld_i |=> !vld_o);                                       // R9
    AST_IDLE_HOLDS : assert property (@(posedge clk) disable iff (!rst_n)
        !vld_i |=> ($stable(sum_lo_o) && $stable(spill_o) && $stable(base_hi_o))); // R9

endmodule

// File: rtl/ptradd_hi_stage.sv
// Module: ptradd_hi_stage
// High-half stage: base upper word plus spilled offset word plus carry.
// Assumes its inputs come from the register that holds its paired low half.
module ptradd_hi_stage
    import ptradd_pkg::*;
(
    input  logic [HALF_W-1:0] base_hi,
    input  spill_t            spill,
    output logic [HALF_W-1:0] sum_hi
);

    // Three-input upper-word sum, wrapping at the half width
    always_comb sum_hi = base_hi + spill.upper + {{(HALF_W-1){1'b0}}, spill.carry};

endmodule

// File: rtl/ptr_shift_adder.sv
// Module: ptr_shift_adder
// Top: base + (extended offset << shift) as two 32-bit halves with a
// pipeline register between them; result is valid one cycle after input.
// Assumes no back-pressure: each accepted operation owns one output cycle.
module ptr_shift_adder
    import ptradd_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  logic               in_valid,
    input  logic [1:0]         in_mode,
    input  logic [SHIFT_W-1:0] in_shift,
    input  logic [PTR_W-1:0]   in_base,
    input  logic [PTR_W-1:0]   in_offset,
    output logic               out_valid,
    output logic [PTR_W-1:0]   out_sum
);

    logic [HALF_W-1:0] lo_sum;
    spill_t            lo_spill;
    logic [HALF_W-1:0] q_sum_lo;
    spill_t            q_spill;
    logic [HALF_W-1:0] q_base_hi;
    logic [HALF_W-1:0] hi_sum;

    ptradd_lo_stage u_lo (
        .mode    (in_mode),
        .shamt   (in_shift),
        .base_lo (in_base[HALF_W-1:0]),
        .offset  (in_offset),
        .sum_lo  (lo_sum),
        .spill   (lo_spill)
    );

    ptradd_pipe u_pipe (
        .clk       (clk),
        .rst_n     (rst_n),
        .vld_i     (in_valid),
        .sum_lo_i  (lo_sum),
        .spill_i   (lo_spill),
        .base_hi_i (in_base[PTR_W-1:HALF_W]),
        .vld_o     (out_valid),
        .sum_lo_o  (q_sum_lo),
        .spill_o   (q_spill),
        .base_hi_o (q_base_hi)
    );

    ptradd_hi_stage u_hi (
        .base_hi (q_base_hi),
        .spill   (q_spill),
        .sum_hi  (hi_sum)
    );

    // Join the halves into the result
    always_comb out_sum = {hi_sum, q_sum_lo};

    AST_FULL_SUM : assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_mode[1] == in_mode[0]) |=>
        out_sum == $past(in_base + (in_offset << in_shift)));     // R2
    AST_ZEXT_SUM : assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_mode == 2'b01) |=>
        out_sum == $past(in_base + ({32'h0, in_offset[31:0]} << in_shift)));  // R3
    AST_SEXT_SUM : assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_mode == 2'b10) |=>
        out_sum == $past(in_base + ({{32{in_offset[31]}}, in_offset[31:0]} << in_shift))); // R4
    AST_OUT_HOLDS : assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> $stable(out_sum));                          // R9

endmodule

// File: tb/sim_ptr_shift_adder.sv
`timescale 1ns/1ps
module sim_ptr_shift_adder;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        in_valid;
    logic [1:0]  in_mode;
    logic [2:0]  in_shift;
    logic [63:0] in_base;
    logic [63:0] in_offset;
    logic        out_valid;
    logic [63:0] out_sum;

    int n_run  = 0;
    int n_fail = 0;
    bit done   = 1'b0;

    always #2 clk = ~clk;   // 250 MHz

    ptr_shift_adder u0 (
        .clk       (clk),
        .rst_n     (rst_n),
        .in_valid  (in_valid),
        .in_mode   (in_mode),
        .in_shift  (in_shift),
        .in_base   (in_base),
        .in_offset (in_offset),
        .out_valid (out_valid),
        .out_sum   (out_sum)
    );

    // Expected sum built from the requirement text
    function automatic logic [63:0] model(input logic [1:0] m, input logic [2:0] s,
                                          input logic [63:0] b, input logic [63:0] o);
        logic [63:0] e;
        if (m == 2'b01)      e = {32'h0, o[31:0]};
        else if (m == 2'b10) e = {{32{o[31]}}, o[31:0]};
        else                 e = o;
        return b + (e << s);
    endfunction

    task automatic chk(input string req, input logic [63:0] got, input logic [63:0] exp);
        n_run++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s: got %h expected %h", req, got, exp);
        end
    endtask

    task automatic put(input logic [1:0] m, input logic [2:0] s,
                       input logic [63:0] b, input logic [63:0] o);
        in_mode = m; in_shift = s; in_base = b; in_offset = o; in_valid = 1'b1;
    endtask

    // One operation, checked one falling edge later
    task automatic run_one(input string req, input logic [1:0] m, input logic [2:0] s,
                           input logic [63:0] b, input logic [63:0] o);
        put(m, s, b, o);
        @(negedge clk);
        in_valid = 1'b0;
        chk(req, {63'h0, out_valid}, 64'h1);
        chk(req, out_sum, model(m, s, b, o));
    endtask

    task automatic t_reset;
        rst_n = 1'b0; in_valid = 1'b0; in_mode = 2'b00; in_shift = 3'd0;
        in_base = '0; in_offset = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1 valid", {63'h0, out_valid}, 64'h0);
        chk("R1 sum", out_sum, 64'h0);
    endtask

    task automatic t_full;
        run_one("R2 shift0", 2'b00, 3'd0, 64'h0000_1000_2000_3000, 64'h0000_0001_0000_0010);
        run_one("R2 shift3", 2'b00, 3'd3, 64'h1234_5678_9ABC_DEF0, 64'h0000_0102_0304_0506);
        run_one("R2 shift7", 2'b00, 3'd7, 64'h0000_0000_0000_0040, 64'h0001_0000_8000_0001);
    endtask

    task automatic t_zext;
        run_one("R3 upper ignored", 2'b01, 3'd2, 64'h0000_0010_0000_0000, 64'hDEAD_BEEF_0000_0100);
        run_one("R3 high bit set", 2'b01, 3'd0, 64'h0000_0000_0000_0000, 64'h5555_5555_8000_0000);
    endtask

    task automatic t_sext;
        run_one("R4 negative", 2'b10, 3'd3, 64'h0000_0001_0000_0000, 64'h1234_5678_FFFF_FFFF);
        run_one("R4 positive", 2'b10, 3'd1, 64'h0000_0000_0000_1000, 64'hFFFF_FFFF_0000_0800);
    endtask

    task automatic t_alt;
        run_one("R5 mode3 as full", 2'b11, 3'd4, 64'h0000_0100_0000_0000, 64'h0000_0002_1000_0000);
    endtask

    task automatic t_carry;
        run_one("R6 low carry", 2'b00, 3'd0, 64'h0000_0005_FFFF_FFFF, 64'h0000_0000_0000_0001);
    endtask

    task automatic t_spill;
        run_one("R7 spill bits", 2'b01, 3'd5, 64'h0000_0000_0000_0000, 64'h0000_0000_F800_0001);
    endtask

    task automatic t_b2b;
        put(2'b00, 3'd1, 64'h0000_0000_0000_0001, 64'h0000_0000_0000_0002);
        @(negedge clk);
        chk("R8 first valid", {63'h0, out_valid}, 64'h1);
        chk("R8 first sum", out_sum, 64'h5);
        put(2'b10, 3'd2, 64'h0000_0000_0000_0100, 64'h0000_0000_FFFF_FFFC);
        @(negedge clk);
        in_valid = 1'b0;
        chk("R8 second valid", {63'h0, out_valid}, 64'h1);
        chk("R8 second sum", out_sum, 64'h0000_0000_0000_00F0);
    endtask

    task automatic t_idle;
        logic [63:0] held;
        held = out_sum;
        put(2'b00, 3'd7, 64'hFFFF_0000_FFFF_0000, 64'h0123_4567_89AB_CDEF);
        in_valid = 1'b0;
        @(negedge clk);
        chk("R9 no valid", {63'h0, out_valid}, 64'h0);
        chk("R9 sum held", out_sum, held);
        @(negedge clk);
        chk("R9 sum still held", out_sum, held);
    endtask

    task automatic t_wrap;
        run_one("R10 wrap", 2'b00, 3'd1, 64'hFFFF_FFFF_FFFF_FFF0, 64'h8000_0000_0000_0010);
    endtask

    initial begin
        t_reset;
        t_full;
        t_zext;
        t_sext;
        t_alt;
        t_carry;
        t_spill;
        t_b2b;
        t_idle;
        t_wrap;
        if (!done) begin
            done = 1'b1;
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

    // Watchdog
    initial begin
        repeat (5000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            n_run++;
            n_fail++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

endmodule